// File: doc/BRIEF.md
# Power Button Sleep-State Controller

This block keeps track of the platform sleep state and turns presses of an active-low power button into the actions that state calls for. The button input is first synchronised and then debounced against a millisecond timebase. The debounced level is always visible as a status bit. A fresh press while the system runs raises a single-cycle SCI or SMI request, depending on three enable bits. A fresh press while the system is suspended raises a wake pulse and returns the state to running.

Holding the button for a parameterised number of timebase ticks while running forces an unconditional move to soft-off. Nothing outside the block has to agree to this move. A stretch-active flag marks the period in which a minimum sleep-signal assertion width is still being enforced. While that flag is set, the button neither wakes the system nor advances the hold timer. If the flag clears while the button is still held, the system wakes, and a full new hold is then needed to force soft-off.

A power-good input moves the block out of mechanical-off. A software sleep request with a target code moves it from running into a suspend state.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: After reset, `state` is G3 and `btn_level`, `wake_pulse`, `sci_pulse` and `smi_pulse` are all low. The state codes are G3=0, S0=1, S1=2, S3=3, S4=4 and S5=5, and `state` never holds any other value.
- R2: `btn_level` is 1 while the debounced button is pressed. It changes only after the synchronised input has differed from it for DB_TICKS consecutive `tick` pulses, so shorter glitches leave it and every pulse output unchanged.
- R3: In G3, button activity changes nothing and raises no pulse. When `pwr_good` is high in G3, the next state is S5, and G3 is never left for any other state.
- R4: In S0, a new debounced press with `sci_en` and `btn_en` both set gives exactly one `sci_pulse` of one cycle. At most one of the three pulse outputs is high in any cycle.
- R5: In S0, a new press with `sci_en` clear and both `btn_en` and `gsmi_en` set gives exactly one `smi_pulse` of one cycle.
- R6: In S0, a new press with `btn_en` clear, or with `sci_en` and `gsmi_en` both clear, gives no SCI and no SMI pulse.
- R7: In S1, S3, S4 or S5, a new debounced press with `stretch_active` low moves the state to S0 and gives one `wake_pulse`.
- R8: While `stretch_active` is high, a press gives no wake and the hold timer does not advance, so a hold of any length in S0 does not force S5.
- R9: If `stretch_active` falls in a suspend state while the debounced button is held, the system wakes to S0 with one `wake_pulse`.
- R10: A debounced hold in S0 with `stretch_active` low forces S5 on its OVR_TICKS-th tick. The count restarts from zero after a release and whenever the state is not S0.
- R11: In S0, `sleep_req` with `sleep_tgt` equal to S1, S3, S4 or S5 moves the state to that target. A request with any other target, or a request in any state other than S0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_n | input | 1 | Raw power button, low when pressed |
| tick | input | 1 | One-cycle timebase pulse (1 ms) |
| pwr_good | input | 1 | Power good; releases G3 into S5 |
| sci_en | input | 1 | SCI routing enable |
| btn_en | input | 1 | Power button event enable |
| gsmi_en | input | 1 | Global SMI enable |
| stretch_active | input | 1 | Minimum sleep-signal stretch in progress |
| sleep_req | input | 1 | Software sleep request, one cycle |
| sleep_tgt | input | 3 | Target state code for `sleep_req` |
| state | output | 3 | Current sleep state code |
| btn_level | output | 1 | Debounced button level, 1 = pressed |
| wake_pulse | output | 1 | One-cycle wake event |
| sci_pulse | output | 1 | One-cycle SCI request |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
A button edge on `btn_n` passes through two synchroniser registers and then the debounce counter. `btn_level` therefore rises two clocks plus DB_TICKS ticks after the raw edge. Each event pulse, and the state change that comes with it, appears one clock after `btn_level` rises, or one clock after `stretch_active` falls for the held-button wake. A `pwr_good`, a sleep request or the terminal override tick takes effect on the next clock edge. The bench model holds these same register stages as integer state and advances them on every rising edge. Every output is compared at the falling edge that follows, so each result is checked in exactly the cycle it is due. Directed checks at the end of each phase confirm the expected state and pulse counts.

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl #(
  parameter int DB_TICKS  = 16,
  parameter int OVR_TICKS = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_n,
  input  logic       tick,
  input  logic       pwr_good,
  input  logic       sci_en,
  input  logic       btn_en,
  input  logic       gsmi_en,
  input  logic       stretch_active,
  input  logic       sleep_req,
  input  logic [2:0] sleep_tgt,
  output logic [2:0] state,
  output logic       btn_level,
  output logic       wake_pulse,
  output logic       sci_pulse,
  output logic       smi_pulse
);
  localparam int DBW = $clog2(DB_TICKS + 1);
  localparam int OVW = $clog2(OVR_TICKS + 1);
  localparam logic [DBW-1:0] DB_LAST  = DBW'(DB_TICKS - 1);
  localparam logic [OVW-1:0] OVR_LAST = OVW'(OVR_TICKS - 1);
  localparam logic [2:0] ST_G3 = 3'd0, ST_S0 = 3'd1, ST_S1 = 3'd2,
                         ST_S3 = 3'd3, ST_S4 = 3'd4, ST_S5 = 3'd5;

  logic [1:0]     sync;
  logic           lvl, lvl_q, str_q;
  logic [DBW-1:0] dbc;
  logic [OVW-1:0] ovr;

  wire raw      = sync[1];
  wire press    = lvl & ~lvl_q;
  wire relaunch = lvl & str_q & ~stretch_active;
  wire hold_ok  = (state == ST_S0) & lvl & ~stretch_active;
  wire ovr_hit  = hold_ok & tick & (ovr == OVR_LAST);
  wire tgt_ok   = (sleep_tgt == ST_S1) | (sleep_tgt == ST_S3) |
                  (sleep_tgt == ST_S4) | (sleep_tgt == ST_S5);

  assign btn_level = lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync  <= '0;
      lvl   <= 1'b0;
      lvl_q <= 1'b0;
      str_q <= 1'b0;
      dbc   <= '0;
    end else begin
      sync  <= {sync[0], ~btn_n};
      lvl_q <= lvl;
      str_q <= stretch_active;
      if (raw == lvl)
        dbc <= '0;
      else if (tick) begin
        if (dbc == DB_LAST) begin
          lvl <= raw;
          dbc <= '0;
        end else
          dbc <= dbc + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ovr <= '0;
    else if (!hold_ok || ovr_hit)
      ovr <= '0;
    else if (tick)
      ovr <= ovr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_G3;
      wake_pulse <= 1'b0;
      sci_pulse  <= 1'b0;
      smi_pulse  <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      sci_pulse  <= 1'b0;
      smi_pulse  <= 1'b0;
      case (state)
        ST_G3: if (pwr_good) state <= ST_S5;
        ST_S0: begin
          if (ovr_hit)
            state <= ST_S5;
          else begin
            if (press && sci_en && btn_en)
              sci_pulse <= 1'b1;
            else if (press && !sci_en && btn_en && gsmi_en)
              smi_pulse <= 1'b1;
            if (sleep_req && tgt_ok)
              state <= sleep_tgt;
          end
        end
        ST_S1, ST_S3, ST_S4, ST_S5:
          if (!stretch_active && (press || relaunch)) begin
            state      <= ST_S0;
            wake_pulse <= 1'b1;
          end
        default: state <= ST_G3;
      endcase
    end
endmodule

// File: rtl/pwrbtn_ctrl_chk.sv
module pwrbtn_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stretch_active,
  input logic [2:0] state,
  input logic       wake_pulse,
  input logic       sci_pulse,
  input logic       smi_pulse
);
  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd5);

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_pulse, sci_pulse, smi_pulse}));

  assert_irq_from_s0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_pulse || smi_pulse) |-> $past(state) == 3'd1);

  assert_g3_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 3'd0 && state != 3'd0) |-> state == 3'd5);

  assert_wake_from_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (state == 3'd1 && $past(state) != 3'd1 && $past(state) != 3'd0));

  assert_no_wake_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !$past(stretch_active));
endmodule

bind pwrbtn_ctrl pwrbtn_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stretch_active(stretch_active), .state(state),
  .wake_pulse(wake_pulse), .sci_pulse(sci_pulse), .smi_pulse(smi_pulse)
);

// File: tb/tb_pwrbtn_ctrl.sv
module tb_pwrbtn_ctrl;
  localparam int DB  = 3;
  localparam int OVR = 20;

  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1, tick = 1'b0, pwr_good = 1'b0;
  logic sci_en = 1'b0, btn_en = 1'b0, gsmi_en = 1'b0, stretch = 1'b0, sleep_req = 1'b0;
  logic [2:0] sleep_tgt = 3'd0;
  logic [2:0] state;
  logic btn_level, wake_pulse, sci_pulse, smi_pulse;

  int checks = 0, fails = 0, tcnt = 0;
  int n_wake = 0, n_sci = 0, n_smi = 0;
  bit done = 0;

  int m_s1, m_s2, m_lvl, m_prev, m_dbc, m_stq, m_ovr, m_state, m_w, m_sci, m_smi;

  always #10 clk = ~clk;

  pwrbtn_ctrl #(.DB_TICKS(DB), .OVR_TICKS(OVR)) dut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .tick(tick), .pwr_good(pwr_good),
    .sci_en(sci_en), .btn_en(btn_en), .gsmi_en(gsmi_en), .stretch_active(stretch),
    .sleep_req(sleep_req), .sleep_tgt(sleep_tgt), .state(state), .btn_level(btn_level),
    .wake_pulse(wake_pulse), .sci_pulse(sci_pulse), .smi_pulse(smi_pulse));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 5;
    tick <= (tcnt == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_prev = 0; m_dbc = 0; m_stq = 0;
      m_ovr = 0; m_state = 0; m_w = 0; m_sci = 0; m_smi = 0;
    end else begin
      int pr, rl, ns, no;
      pr = m_lvl && !m_prev;
      rl = m_lvl && m_stq && !stretch;
      ns = m_state; no = 0; m_w = 0; m_sci = 0; m_smi = 0;
      if (m_state == 0) begin
        if (pwr_good) ns = 5;
      end else if (m_state == 1) begin
        if (m_lvl && !stretch) no = tick ? m_ovr + 1 : m_ovr;
        if (no == OVR) begin ns = 5; no = 0; end
        else begin
          if (pr && sci_en && btn_en) m_sci = 1;
          else if (pr && !sci_en && btn_en && gsmi_en) m_smi = 1;
          if (sleep_req && sleep_tgt >= 2) ns = sleep_tgt;
        end
      end else if (!stretch && (pr || rl)) begin
        ns = 1; m_w = 1;
      end
      m_state = ns; m_ovr = no;
      m_prev = m_lvl;
      if (m_s2 == m_lvl) m_dbc = 0;
      else if (tick) begin
        m_dbc++;
        if (m_dbc == DB) begin m_lvl = m_s2; m_dbc = 0; end
      end
      m_s2 = m_s1; m_s1 = !btn_n; m_stq = stretch;
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_wake += wake_pulse; n_sci += sci_pulse; n_smi += smi_pulse;
    chk("R1 state vs model", state, m_state);
    chk("R2 btn_level vs model", btn_level, m_lvl);
    chk("R4 sci_pulse vs model", sci_pulse, m_sci);
    chk("R5 smi_pulse vs model", smi_pulse, m_smi);
    chk("R7 wake_pulse vs model", wake_pulse, m_w);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n);
    btn_n = 1'b0; wait_n(n); btn_n = 1'b1; wait_n(40);
  endtask

  task automatic sleep_to(input logic [2:0] t);
    sleep_tgt = t; sleep_req = 1'b1; wait_n(1); sleep_req = 1'b0; wait_n(2);
  endtask

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(1);
    chk("R1 reset state", state, 0);
    chk("R1 reset level", btn_level, 0);
    chk("R1 reset pulses", wake_pulse + sci_pulse + smi_pulse, 0);

    press(60);
    chk("R3 G3 press ignored", state, 0);
    chk("R3 G3 no pulses", n_wake + n_sci + n_smi, 0);
    pwr_good = 1'b1; wait_n(3);
    chk("R3 power good to S5", state, 5);

    press(40);
    chk("R7 wake from S5", state, 1);
    chk("R7 one wake pulse", n_wake, 1);

    sci_en = 1'b1; btn_en = 1'b1;
    btn_n = 1'b0; wait_n(30);
    chk("R2 level while held", btn_level, 1);
    btn_n = 1'b1; wait_n(40);
    chk("R4 one SCI", n_sci, 1);
    sci_en = 1'b0; gsmi_en = 1'b1; press(40);
    chk("R5 one SMI", n_smi, 1);
    chk("R5 no extra SCI", n_sci, 1);
    btn_en = 1'b0; press(40);
    btn_en = 1'b1; gsmi_en = 1'b0; press(40);
    chk("R6 no SCI/SMI when disabled", n_sci + n_smi, 2);

    sci_en = 1'b1;
    btn_n = 1'b0; wait_n(6); btn_n = 1'b1; wait_n(40);
    chk("R2 glitch no level", btn_level, 0);
    chk("R2 glitch no pulse", n_sci, 1);

    sleep_to(3'd3);
    chk("R11 sleep to S3", state, 3);
    sleep_to(3'd2);
    chk("R11 request outside S0 ignored", state, 3);

    stretch = 1'b1; btn_n = 1'b0; wait_n(60);
    chk("R8 no wake during stretch", state, 3);
    stretch = 1'b0; wait_n(3);
    chk("R9 wake at stretch end", state, 1);
    chk("R9 wake pulse count", n_wake, 2);
    wait_n(60);
    chk("R10 fresh hold not yet S5", state, 1);
    wait_n(80);
    chk("R10 override to S5", state, 5);
    btn_n = 1'b1; wait_n(40);

    press(40);
    chk("R7 wake again", state, 1);
    stretch = 1'b1; btn_n = 1'b0; wait_n(150);
    chk("R8 no override during stretch", state, 1);
    btn_n = 1'b1; wait_n(40); stretch = 1'b0; wait_n(2);
    press(60);
    chk("R10 short hold no override", state, 1);

    sleep_to(3'd0);
    chk("R11 bad target ignored", state, 1);
    sleep_to(3'd2);
    chk("R11 sleep to S1", state, 2);
    press(40);
    chk("R7 wake from S1", state, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule